// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master. It runs one read or one write transaction at a time on the two-wire management interface of an Ethernet PHY, where MDC is the clock and MDIO is the data line. Software reaches it through a small register port with two registers: a control word and a 16-bit data word. The control word selects the PHY, the register inside that PHY, the direction and an MDC clock-range code. Software launches a transaction by writing the control word with its busy bit set. Hardware clears the busy bit when the frame is complete.

MDC is divided down from the system clock, with the divisor picked by the clock-range code. During a frame the block drives the preamble, the start and opcode bits and the two address fields. For a write it then drives the turnaround bits and the 16 data bits. For a read it releases the line and shifts the 16 data bits returned by the PHY into the data register. MDIO appears as three separate signals (output value, output enable and input), so a pad or tri-state buffer outside the block completes the pin.

Top module: `mdio_master`

## Requirements
- R1: After reset, both registers read as zero, MDC is low and MDIO is not driven.
- R2: With `reg_sel`=0 a read returns the control word: PHY address in bits 15:11, register address in bits 10:6, range code in bits 4:2, direction in bit 1 (1 = write) and busy in bit 0. Bits 31:16 and bit 5 read as zero. With `reg_sel`=1 a read returns the data word in bits 15:0, with the upper half zero. Register reads appear on `reg_rdata` one cycle after `reg_rd`.
- R3: Range codes 0, 1, 2 and 3 give an MDC period of 42, 62, 16 and 26 system clocks respectively. The high and low halves are equal. The first rising edge comes half a period after the launching write.
- R4: Range codes 4 to 7 use the slowest period, 62 clocks.
- R5: Every frame starts with 32 ones, then 0 and 1, then the opcode (1,0 for a read and 0,1 for a write), then the 5-bit PHY address and the 5-bit register address, each most significant bit first.
- R6: A write continues with turnaround bits 1,0 and then the 16 bits of the data word, most significant bit first. The output enable stays high for all 64 bit periods, and the data word keeps its value.
- R7: A read releases MDIO for the two turnaround bits and for the 16 data bits. It samples MDIO at each rising MDC edge of the data bits, and the data word holds the result when busy clears.
- R8: Busy is set only by a control write with bit 0 at 1 while idle. It stays set for exactly 64 MDC periods and clears at the edge of the last falling MDC edge. While busy is clear, MDC is low and MDIO is released.
- R9: While busy, writes to either register change neither register nor the frame on the wire. This includes a control write that has bit 0 set.
- R10: During a transaction, the MDIO value and enable change only together with a falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 control word, 1 data word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pin |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble and divisors of 42, 62, 16 and 26. Every frame on the wire therefore has its full 64-bit length, and the busy window and edge timings are checked against the exact counts that software will see. Reserved range codes fall back to the slowest clock, so with these values the fallback is checked against 62 clocks as well. A PHY model in the bench drives known read data back on MDIO, which lets the capture order and the turnaround release be checked at the pin. Writes are issued in the middle of every frame so that the busy lock is exercised for all four divisors.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;
  localparam int unsigned PHY_DATA_W = 16;

  typedef struct packed {
    logic [4:0] phy_addr;
    logic [4:0] reg_addr;
    logic [2:0] range_code;
    logic       write_op;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t decode_ctrl(input logic [15:0] w);
    mgmt_cmd_t c;
    c.phy_addr   = w[15:11];
    c.reg_addr   = w[10:6];
    c.range_code = w[4:2];
    c.write_op   = w[1];
    return c;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_C0 = 42,
  parameter int unsigned DIV_C1 = 62,
  parameter int unsigned DIV_C2 = 16,
  parameter int unsigned DIV_C3 = 26
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       start,
  input  logic [2:0] range_code,
  output logic       mdc,
  output logic       rise_now,
  output logic       fall_now
);

  localparam int unsigned DIV_MAX = mdio_pkg::max4(DIV_C0, DIV_C1, DIV_C2, DIV_C3);
  localparam int unsigned CNT_W   = $clog2(DIV_MAX / 2 + 1);

  logic [CNT_W-1:0] half_tab [4];
  logic [CNT_W-1:0] half_sel;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  // Half-period table, one entry per defined range code.
  for (genvar g = 0; g < 4; g++) begin : g_tab
    localparam int unsigned DV = (g == 0) ? DIV_C0 :
                                 (g == 1) ? DIV_C1 :
                                 (g == 2) ? DIV_C2 : DIV_C3;
    assign half_tab[g] = CNT_W'(DV / 2);
  end

  // Reserved codes fall back to the slowest clock.
  always_comb begin
    if (range_code[2]) half_sel = CNT_W'(DIV_MAX / 2);
    else               half_sel = half_tab[range_code[1:0]];
  end

  assign tick     = run && (cnt_q == half_q - 1'b1);
  assign rise_now = tick && !mdc;
  assign fall_now = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= CNT_W'(DIV_MAX / 2);
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else begin
      if (start) half_q <= half_sel;
      if (start || !run || tick) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
      if (!run)      mdc <= 1'b0;
      else if (tick) mdc <= ~mdc;
    end
  end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  mdio_pkg::mgmt_cmd_t                cmd,
  input  logic [mdio_pkg::PHY_DATA_W-1:0]    tx_data,
  input  logic                               rise_now,
  input  logic                               fall_now,
  input  logic                               mdio_i,
  output logic                               mdio_o,
  output logic                               mdio_oe,
  output logic                               done,
  output logic [mdio_pkg::PHY_DATA_W-1:0]    rx_data
);

  localparam int unsigned DW        = mdio_pkg::PHY_DATA_W;
  localparam int unsigned FRAME_LEN = PRE_LEN + 16 + DW;
  localparam int unsigned SLOT_W    = $clog2(FRAME_LEN);
  localparam int unsigned TA_SLOT   = PRE_LEN + 14;
  localparam int unsigned DATA_SLOT = PRE_LEN + 16;
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W-1:0] TA_IDX   = SLOT_W'(TA_SLOT - 1);
  localparam logic [SLOT_W-1:0] DATA_IDX = SLOT_W'(DATA_SLOT);

  logic [FRAME_LEN-1:0] frame_init;
  logic [FRAME_LEN-1:0] sh_q;
  logic [SLOT_W-1:0]    slot_q;
  logic                 is_wr_q;
  logic [DW-1:0]        rx_q;

  always_comb begin
    frame_init = {{PRE_LEN{1'b1}}, 2'b01,
                  (cmd.write_op ? 2'b01 : 2'b10),
                  cmd.phy_addr, cmd.reg_addr,
                  (cmd.write_op ? 2'b10 : 2'b00),
                  (cmd.write_op ? tx_data : {DW{1'b0}})};
  end

  assign done    = fall_now && (slot_q == LAST_IDX);
  assign rx_data = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      slot_q  <= '0;
      is_wr_q <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rx_q    <= '0;
    end else if (start) begin
      sh_q    <= frame_init;
      slot_q  <= '0;
      is_wr_q <= cmd.write_op;
      mdio_o  <= frame_init[FRAME_LEN-1];
      mdio_oe <= 1'b1;
    end else if (fall_now) begin
      if (slot_q == LAST_IDX) begin
        slot_q  <= '0;
        mdio_o  <= 1'b0;
        mdio_oe <= 1'b0;
      end else begin
        slot_q  <= slot_q + 1'b1;
        sh_q    <= {sh_q[FRAME_LEN-2:0], 1'b0};
        mdio_o  <= sh_q[FRAME_LEN-2];
        mdio_oe <= is_wr_q || (slot_q < TA_IDX);
      end
    end else if (rise_now && !is_wr_q && (slot_q >= DATA_IDX)) begin
      rx_q <= {rx_q[DW-2:0], mdio_i};
    end
  end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            reg_wr,
  input  logic                            reg_rd,
  input  logic                            reg_sel,
  input  logic [15:0]                     wdata_lo,
  input  mdio_pkg::mgmt_cmd_t             cmd_new,
  input  logic                            done,
  input  logic [mdio_pkg::PHY_DATA_W-1:0] rx_data,
  output mdio_pkg::mgmt_cmd_t             cmd_q,
  output logic [mdio_pkg::PHY_DATA_W-1:0] data_q,
  output logic                            busy,
  output logic                            start,
  output logic [31:0]                     reg_rdata
);

  logic ctrl_wr;
  logic data_wr;

  assign ctrl_wr = reg_wr && (reg_sel == mdio_pkg::SEL_CTRL) && !busy;
  assign data_wr = reg_wr && (reg_sel == mdio_pkg::SEL_DATA) && !busy;
  assign start   = ctrl_wr && wdata_lo[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      data_q    <= '0;
      busy      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (start)     busy <= 1'b1;
      else if (done) busy <= 1'b0;

      if (ctrl_wr) cmd_q <= cmd_new;

      if (done && !cmd_q.write_op) data_q <= rx_data;
      else if (data_wr)            data_q <= wdata_lo;

      if (reg_rd) begin
        if (reg_sel == mdio_pkg::SEL_DATA)
          reg_rdata <= {16'h0000, data_q};
        else
          reg_rdata <= {16'h0000, cmd_q.phy_addr, cmd_q.reg_addr, 1'b0,
                        cmd_q.range_code, cmd_q.write_op, busy};
      end
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned DIV_C0  = 42,
  parameter int unsigned DIV_C1  = 62,
  parameter int unsigned DIV_C2  = 16,
  parameter int unsigned DIV_C3  = 26
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  mdio_pkg::mgmt_cmd_t cmd_new_w;
  mdio_pkg::mgmt_cmd_t cmd_q_w;
  logic [mdio_pkg::PHY_DATA_W-1:0] data_q_w;
  logic [mdio_pkg::PHY_DATA_W-1:0] rx_w;
  logic busy_w, start_w, done_w, rise_w, fall_w;
  logic unused_bits;

  assign unused_bits = ^{reg_wdata[31:16], reg_wdata[5]};
  assign cmd_new_w   = mdio_pkg::decode_ctrl(reg_wdata[15:0]);

  mdio_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .wdata_lo  (reg_wdata[15:0]),
    .cmd_new   (cmd_new_w),
    .done      (done_w),
    .rx_data   (rx_w),
    .cmd_q     (cmd_q_w),
    .data_q    (data_q_w),
    .busy      (busy_w),
    .start     (start_w),
    .reg_rdata (reg_rdata)
  );

  mdio_clkgen #(
    .DIV_C0 (DIV_C0),
    .DIV_C1 (DIV_C1),
    .DIV_C2 (DIV_C2),
    .DIV_C3 (DIV_C3)
  ) u_clkgen (
    .clk        (clk),
    .rst        (rst),
    .run        (busy_w),
    .start      (start_w),
    .range_code (cmd_new_w.range_code),
    .mdc        (mdc),
    .rise_now   (rise_w),
    .fall_now   (fall_w)
  );

  mdio_frame #(
    .PRE_LEN (PRE_LEN)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .start    (start_w),
    .cmd      (cmd_new_w),
    .tx_data  (data_q_w),
    .rise_now (rise_w),
    .fall_now (fall_w),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done_w),
    .rx_data  (rx_w)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic        reg_sel,
  input logic        start_bit,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic [13:0] cmd_bits
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe)); // R8

  AST_BUSY_BY_SW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && !reg_sel && start_bit)); // R8

  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R10

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_bits)); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_sel) |=> (reg_rdata[31:16] == 16'h0000 && !reg_rdata[5])); // R2

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_sel   (reg_sel),
  .start_bit (reg_wdata[0]),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .busy      (busy_w),
  .cmd_bits  (cmd_q_w)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        dir;
    logic [2:0]  code;
    logic [4:0]  pa;
    logic [4:0]  ra;
    logic [15:0] wval;
    logic [15:0] pval;
    logic [6:0]  div;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 3'd0, 5'h01, 5'h04, 16'hA5C3, 16'h0000, 7'd42},
    '{1'b0, 3'd1, 5'h1F, 5'h00, 16'h1111, 16'h8001, 7'd62},
    '{1'b1, 3'd2, 5'h10, 5'h1F, 16'h7E81, 16'h0000, 7'd16},
    '{1'b0, 3'd3, 5'h0A, 5'h15, 16'h2222, 16'h5A3C, 7'd26},
    '{1'b0, 3'd5, 5'h03, 5'h11, 16'h3333, 16'hFFFF, 7'd62},
    '{1'b1, 3'd7, 5'h1C, 5'h02, 16'h0001, 16'h0000, 7'd62}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  // PHY model state
  logic [15:0] phy_val = '0;
  logic        phy_rd = 1'b0;
  int rise_n = 0, fall_n = 0, rise_base = 0, fall_base = 0;
  logic cap_o [64];
  logic cap_oe [64];
  int   rise_t [64];

  mdio_master dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin : phy_rise
    int k;
    #1;
    k = rise_n - rise_base;
    if (k >= 0 && k < 64) begin
      cap_o[k]  = mdio_o;
      cap_oe[k] = mdio_oe;
      rise_t[k] = cyc;
    end
    rise_n = rise_n + 1;
  end

  always @(negedge mdc) begin : phy_fall
    int s;
    fall_n = fall_n + 1;
    s = fall_n - fall_base;
    if (phy_rd && s >= 48 && s < 64) mdio_i = phy_val[63 - s];
    else                             mdio_i = 1'b1;
  end

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_at(input int t, input logic sel, input logic [31:0] d);
    @(negedge clk);
    while (cyc < t - 1) @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_at(input int t, input logic sel, output logic [31:0] d);
    @(negedge clk);
    while (cyc < t - 1) @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] r, ctl;
    logic [45:0] hdr;
    logic [17:0] tail;
    int d, e0, bad_h, bad_t, bad_p;
    string rq;
    d  = int'(v.div);
    rq = (v.code < 3'd4) ? "R3" : "R4";
    write_at(cyc + 2, 1'b1, {16'hFFFF, v.wval});
    phy_val = v.pval; phy_rd = !v.dir;
    rise_base = rise_n; fall_base = fall_n;
    ctl = {16'h0, v.pa, v.ra, 1'b0, v.code, v.dir, 1'b1};
    e0 = cyc + 2;
    write_at(e0, 1'b0, ctl);
    // R9: writes in flight must be ignored, including a second launch
    write_at(e0 + 10, 1'b0, {16'h0, ~v.pa, ~v.ra, 1'b0, ~v.code, ~v.dir, 1'b1});
    write_at(e0 + 12, 1'b1, 32'h0000_DEAD);
    read_at(e0 + 14, 1'b0, r);
    check32("R9", "control locked while busy", r, ctl);
    read_at(e0 + 64*d - 1, 1'b0, r);
    check32("R8", "busy one cycle before end", r, ctl);
    read_at(e0 + 64*d + 1, 1'b0, r);
    check32("R8", "busy cleared after frame", r, ctl & 32'hFFFF_FFFE);
    read_at(e0 + 64*d + 3, 1'b1, r);
    if (v.dir) check32("R6", "write data word kept", r, {16'h0, v.wval});
    else       check32("R7", "read data captured", r, {16'h0, v.pval});
    check32("R8", "idle pins", {30'h0, mdc, mdio_oe}, 32'h0);
    check32("R8", "mdc rise count", rise_n - rise_base, 64);
    hdr  = {32'hFFFF_FFFF, 2'b01, (v.dir ? 2'b01 : 2'b10), v.pa, v.ra};
    tail = {2'b10, v.wval};
    bad_h = 0; bad_t = 0; bad_p = 0;
    for (int k = 0; k < 46; k++)
      if (cap_oe[k] !== 1'b1 || cap_o[k] !== hdr[45 - k]) bad_h++;
    for (int k = 46; k < 64; k++) begin
      if (v.dir) begin
        if (cap_oe[k] !== 1'b1 || cap_o[k] !== tail[63 - k]) bad_t++;
      end else if (cap_oe[k] !== 1'b0) bad_t++;
    end
    check32("R5", "header bit mismatches", bad_h, 0);
    if (v.dir) check32("R6", "write tail mismatches", bad_t, 0);
    else       check32("R7", "read release mismatches", bad_t, 0);
    if (rise_t[0] != e0 + d/2) bad_p++;
    for (int k = 1; k < 64; k++)
      if (rise_t[k] - rise_t[k-1] != d) bad_p++;
    check32(rq, "mdc period errors", bad_p, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check32("R1", "pins after reset", {29'h0, mdc, mdio_oe, mdio_o}, 32'h0);
    read_at(cyc + 2, 1'b0, r);
    check32("R1", "control after reset", r, 32'h0);
    read_at(cyc + 2, 1'b1, r);
    check32("R1", "data after reset", r, 32'h0);
    // R2 layout, reserved bits zero, no launch when bit 0 clear
    write_at(cyc + 2, 1'b0, 32'hFFFF_FFFE);
    read_at(cyc + 2, 1'b0, r);
    check32("R2", "control readback", r, 32'h0000_FFDE);
    repeat (40) @(negedge clk);
    check32("R8", "no launch without busy bit", {30'h0, mdc, mdio_oe}, 32'h0);
    write_at(cyc + 2, 1'b1, 32'hFFFF_1234);
    read_at(cyc + 2, 1'b1, r);
    check32("R2", "data readback", r, 32'h0000_1234);
    // vector table covering R3..R10
    for (int i = 0; i < 6; i++) run_vec(VECS[i]);
    // directed: back-to-back launch right after completion
    write_at(cyc + 2, 1'b0, {16'h0, 5'h05, 5'h06, 1'b0, 3'd2, 1'b1, 1'b1});
    repeat (3) @(negedge clk);
    check32("R8", "relaunch drives bus", {31'h0, mdio_oe}, 32'h1);
    repeat (64*16 + 4) @(negedge clk);
    read_at(cyc + 2, 1'b0, r);
    check32("R8", "relaunch completes", r, {16'h0, 5'h05, 5'h06, 1'b0, 3'd2, 1'b1, 1'b0});
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule